// File: doc/BRIEF.md
# Reference Clock Power Sequencer

This block decides when the clock multiplier and the serial I/O of a link are powered. Its inputs are two mode pins and a reference clock. It runs on a free-running sampling clock. The reference clock is treated as an ordinary input: it passes through a two-flop synchronizer, and the block looks for edges on the result. Its outputs are an enable for the multiplier, an enable for the serial I/O, an enable for the bias references, and a data-valid flag. The data-valid flag tells the parallel port that captured data can be trusted.

There are two low-power states.

- **Mode-off.** The block enters it when both mode pins are low. Every enable drops. Coming back out costs the long lock wait.
- **Clock-stopped sleep.** The block enters it when the reference clock stops, held at either level. The multiplier and serial I/O shut down, but the references stay powered. For that reason, relocking costs only the short wait.

Lock is not taken from an analog detector. The block counts rising edges of the synchronized reference clock.

Top module: `refclk_power_seq`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, the outputs `pll_en`, `sio_en`, `refs_en` and `data_valid` are all low.
- R2: Once `mode` = 2'b00 has been accepted, all four outputs are low. This holds from any state, including clock-stopped sleep.
- R3: When a nonzero `mode` is accepted while `ref_clk` toggles, `pll_en`, `sio_en` and `refs_en` go high and `data_valid` stays low.
- R4: After power-up from mode-off, `data_valid` rises only after `FULL_WAIT` rising edges of `ref_clk` have been counted, with a tolerance of one edge for synchronization.
- R5: If `ref_clk` shows no edge for `STOP_CYCLES` sampling cycles while powered, whether held high or held low, then `pll_en`, `sio_en` and `data_valid` go low and `refs_en` stays high.
- R6: In clock-stopped sleep, the first `ref_clk` transition raises `pll_en` and `sio_en` again. `data_valid` then follows after `SHORT_WAIT` rising edges, not `FULL_WAIT`.
- R7: A nonzero `mode` with a stopped `ref_clk` leaves the block in mode-off with all outputs low.
- R8: A `mode` value is accepted only after it is seen unchanged on two consecutive synchronized samples. A value that lasts a single sampling cycle has no effect on the outputs.
- R9: `data_valid` high implies that all three enables are high, and `pll_en` high implies that `refs_en` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_clk | input | 1 | Reference clock, sampled asynchronously |
| mode | input | 2 | Mode pins; 2'b00 means off, any other value means on |
| pll_en | output | 1 | Clock multiplier enable |
| sio_en | output | 1 | Serial I/O enable |
| refs_en | output | 1 | Bias references enable |
| data_valid | output | 1 | Lock wait elapsed; parallel data may be captured |

## Verification
The assertions check on every cycle the implications between the outputs: valid needs all enables, and the multiplier needs the references. They also check that a long-held off mode clears every enable, and that valid only rises out of a locked state. The bench's scenarios are needed for the rest:

- the length of the two lock waits, counted in reference edges;
- detection of a stopped clock held at either level;
- the choice of the short wait after sleep versus the long wait after mode-off;
- rejection of a single-cycle mode glitch.

// File: rtl/refclk_power_seq.sv
module refclk_power_seq #(
  parameter int STOP_CYCLES = 64,
  parameter int FULL_WAIT   = 4096,
  parameter int SHORT_WAIT  = 256
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ref_clk,
  input  logic [1:0] mode,
  output logic       pll_en,
  output logic       sio_en,
  output logic       refs_en,
  output logic       data_valid
);
  localparam int IW = $clog2(STOP_CYCLES + 1);
  localparam int LW = $clog2(FULL_WAIT + 1);

  typedef enum logic [2:0] {S_OFF, S_LOCK, S_RUN, S_SLEEP, S_RELOCK} st_t;

  st_t          state, state_nx;
  logic [2:0]   ref_s;
  logic [1:0]   m1, m2, m3, mode_acc;
  logic [IW-1:0] idle_cnt;
  logic [LW-1:0] lock_cnt;

  wire ref_edge = ref_s[2] ^ ref_s[1];
  wire ref_rise = ref_s[1] & ~ref_s[2];
  wire stopped  = (idle_cnt == IW'(STOP_CYCLES));
  wire mode_on  = |mode_acc;
  wire [LW-1:0] lock_last = (state == S_RELOCK) ? LW'(SHORT_WAIT - 1) : LW'(FULL_WAIT - 1);
  wire lock_done = ref_rise && (lock_cnt == lock_last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_s    <= '0;
      m1       <= '0;
      m2       <= '0;
      m3       <= '0;
      mode_acc <= '0;
    end else begin
      ref_s <= {ref_s[1:0], ref_clk};
      m1    <= mode;
      m2    <= m1;
      m3    <= m2;
      if (m2 == m3) mode_acc <= m2;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        idle_cnt <= '0;
    else if (ref_edge) idle_cnt <= '0;
    else if (!stopped) idle_cnt <= idle_cnt + 1'b1;
  end

  always_comb begin
    state_nx = state;
    if (!mode_on) state_nx = S_OFF;
    else begin
      case (state)
        S_OFF:    if (ref_edge) state_nx = S_LOCK;
        S_LOCK,
        S_RELOCK: if (stopped) state_nx = S_SLEEP;
                  else if (lock_done) state_nx = S_RUN;
        S_RUN:    if (stopped) state_nx = S_SLEEP;
        S_SLEEP:  if (ref_edge) state_nx = S_RELOCK;
        default:  state_nx = S_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_OFF;
      lock_cnt <= '0;
    end else begin
      state <= state_nx;
      if (state_nx != state) lock_cnt <= '0;
      else if (ref_rise && (state == S_LOCK || state == S_RELOCK)) lock_cnt <= lock_cnt + 1'b1;
    end
  end

  assign pll_en     = (state == S_LOCK) || (state == S_RUN) || (state == S_RELOCK);
  assign sio_en     = pll_en;
  assign refs_en    = (state != S_OFF);
  assign data_valid = (state == S_RUN);
endmodule

module refclk_power_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] mode,
  input logic       pll_en,
  input logic       sio_en,
  input logic       refs_en,
  input logic       data_valid
);
  a_r9_valid_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
    data_valid |-> (pll_en && sio_en && refs_en));

  a_r9_pll_needs_refs: assert property (@(posedge clk) disable iff (!rst_n)
    pll_en |-> refs_en);

  a_r2_off_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b00 && $past(mode) == 2'b00 && $past(mode, 2) == 2'b00 &&
     $past(mode, 3) == 2'b00 && $past(mode, 4) == 2'b00) |=> (!refs_en && !pll_en && !data_valid));

  a_r4_valid_from_lock: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(data_valid) |-> $past(pll_en));

  a_r5_sleep_keeps_refs: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(pll_en) && refs_en) |-> (!sio_en && !data_valid));
endmodule

bind refclk_power_seq refclk_power_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mode(mode), .pll_en(pll_en),
  .sio_en(sio_en), .refs_en(refs_en), .data_valid(data_valid)
);

// File: tb/tb_refclk_power_seq.sv
module tb_refclk_power_seq;
  localparam int STOP  = 16;
  localparam int FULLW = 32;
  localparam int SHORTW = 8;
  localparam int NSTEP = 16;

  logic clk = 0, rst_n = 0, ref_clk = 0;
  logic [1:0] mode = 2'b00;
  logic [1:0] ref_mode = 2'd0;
  logic pll_en, sio_en, refs_en, data_valid;
  int checks = 0, fails = 0, cyc = 0, ref_rises = 0, ph = 0;

  refclk_power_seq #(.STOP_CYCLES(STOP), .FULL_WAIT(FULLW), .SHORT_WAIT(SHORTW)) dut (
    .clk(clk), .rst_n(rst_n), .ref_clk(ref_clk), .mode(mode),
    .pll_en(pll_en), .sio_en(sio_en), .refs_en(refs_en), .data_valid(data_valid));

  always #10 clk = ~clk;

  // ref_mode: 0 toggle every 2 cycles, 1 hold low, 2 hold high
  always @(negedge clk) begin
    if (ref_mode == 2'd0) begin
      ph <= ph + 1;
      if (ph % 2 == 1) ref_clk <= ~ref_clk;
    end else ref_clk <= (ref_mode == 2'd2);
  end

  always @(posedge ref_clk) ref_rises <= ref_rises + 1;

  // {mode, ref_mode, cycles, expected {pll,sio,refs,valid}}, tag index -> requirement
  localparam logic [19:0] TAB [0:NSTEP-1] = '{
    {2'b00, 2'd0, 12'd20,  4'b0000},  // R2
    {2'b01, 2'd1, 12'd40,  4'b0000},  // R7
    {2'b01, 2'd0, 12'd20,  4'b1110},  // R3
    {2'b01, 2'd0, 12'd200, 4'b1111},  // R4
    {2'b01, 2'd2, 12'd40,  4'b0010},  // R5 held high
    {2'b01, 2'd0, 12'd10,  4'b1110},  // R6
    {2'b01, 2'd0, 12'd60,  4'b1111},  // R6 short wait
    {2'b10, 2'd0, 12'd20,  4'b1111},  // R3
    {2'b00, 2'd0, 12'd10,  4'b0000},  // R2
    {2'b11, 2'd0, 12'd20,  4'b1110},  // R3
    {2'b11, 2'd0, 12'd200, 4'b1111},  // R4
    {2'b11, 2'd1, 12'd40,  4'b0010},  // R5 held low
    {2'b00, 2'd1, 12'd10,  4'b0000},  // R2 override sleep
    {2'b01, 2'd0, 12'd10,  4'b1110},  // R4
    {2'b01, 2'd0, 12'd60,  4'b1110},  // R4 full wait after off
    {2'b01, 2'd0, 12'd100, 4'b1111}   // R4
  };
  localparam string TAG [0:NSTEP-1] = '{"R2","R7","R3","R4","R5","R6","R6","R3",
                                         "R2","R3","R4","R5","R2","R4","R4","R4"};

  task automatic check(input string req, input logic [3:0] got, input logic [3:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: outputs got %b expected %b at cycle %0d", req, got, exp, cyc);
    end
  endtask

  task automatic check_cnt(input string req, input int got, input int lo, input int hi);
    checks++;
    if (got < lo || got > hi) begin
      fails++;
      $display("FAIL %s: count got %0d expected %0d..%0d", req, got, lo, hi);
    end
  endtask

  function automatic logic [3:0] outs();
    return {pll_en, sio_en, refs_en, data_valid};
  endfunction

  task automatic run(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 0;
    run(3);
    check("R1", outs(), 4'b0000);
    rst_n = 1;
    @(negedge clk);
    check("R1", outs(), 4'b0000);
  endtask

  task automatic measure_wait(input string req, input int wexp);
    int r0, n;
    n = 0;
    while (!pll_en && n < 2000) begin @(negedge clk); n++; end
    r0 = ref_rises;
    n = 0;
    while (!data_valid && n < 5000) begin @(negedge clk); n++; end
    check_cnt(req, ref_rises - r0, wexp - 1, wexp + 1);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    do_reset();
    for (int s = 0; s < NSTEP; s++) begin
      mode     = TAB[s][19:18];
      ref_mode = TAB[s][17:16];
      run(int'(TAB[s][15:4]));
      check(TAG[s], outs(), TAB[s][3:0]);
    end

    // R4 exact long wait from mode-off
    mode = 2'b00; ref_mode = 2'd0; run(10);
    mode = 2'b10;
    measure_wait("R4", FULLW);

    // R8 one-cycle glitch to off is ignored while running
    mode = 2'b00; @(negedge clk); mode = 2'b10;
    run(10);
    check("R8", outs(), 4'b1111);

    // R8 one-cycle glitch to on is ignored while off
    mode = 2'b00; run(10);
    mode = 2'b01; @(negedge clk); mode = 2'b00;
    run(10);
    check("R8", outs(), 4'b0000);

    // R6 exact short wait after sleep
    mode = 2'b01; run(200);
    ref_mode = 2'd2; run(40);
    check("R5", outs(), 4'b0010);
    ref_mode = 2'd0;
    measure_wait("R6", SHORTW);

    // R1 reset in the middle of operation
    do_reset();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule